// File: doc/BRIEF.md
# Synchronous Bus Master with Wait States

This block sits between a processor's local request port and a clocked, single-master memory bus. It turns one local request into one single-word read or write on the bus. The bus transfer moves through named phases. T1 presents the address. T2 is the first data phase. T3 completes the transfer. The slave holds the transfer in extra Tw phases for as long as it keeps its WAIT line high.

The local side is a valid/ready handshake that carries the address, the write data and the direction. A one-cycle response pulse returns the read data and an error flag. The data bus is split into a drive value, an output enable and an input value, so the pad ring can build the bidirectional pins. A transfer that stays in wait phases longer than a parameterised limit is abandoned and reported as an error.

Top module: `sbus_master`

## Requirements
- R1: Out of reset `req_ready` is 1 and `bus_as`, `bus_doe` and `rsp_valid` are 0. `req_ready` is 1 only while no transfer is in progress. A request is taken on a rising edge where `req_valid` and `req_ready` are both 1.
- R2: With WAIT low, the cycle after acceptance is T1, and `rsp_valid` is high in the third cycle after acceptance (T3).
- R3: `bus_addr` carries the request address and `bus_rnw` carries the inverse of `req_write` (1 = read). Both hold steady in every cycle in which `bus_as` is high.
- R4: `bus_as` is high in T1, T2, every Tw and T3. After every transfer it is low for at least one cycle before the next T1.
- R5: `bus_doe` is high only for write transfers, from T2 through T3. It is never high in T1, on a read, or while idle. While it is high, `bus_dout` equals the request's write data.
- R6: WAIT is sampled on the rising edge at the end of T2 and at the end of each Tw. Each high sample inserts one Tw, so a transfer with N high samples has `bus_as` high for N+3 cycles and responds N+3 cycles after acceptance.
- R7: For a read, the value on `bus_din` at the rising edge where WAIT is sampled low (the edge that ends T2 or the last Tw) is returned on `rsp_rdata` with `rsp_valid`, and `rsp_err` is 0. Writes return `rsp_rdata` = 0.
- R8: WAIT is ignored when it is high in T1 or T3. It neither lengthens nor shortens the transfer.
- R9: If WAIT is still high at the end of the WAIT_LIMIT-th Tw, the transfer is aborted. In the next cycle `bus_as` and `bus_doe` are 0, `rsp_valid` and `rsp_err` are 1, and `rsp_rdata` is 0. After that cycle the block is idle.
- R10: Every accepted request produces exactly one response, and `rsp_valid` is never high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Local request present |
| req_ready | output | 1 | Block is idle and can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Completion was a wait timeout |
| rsp_rdata | output | DATA_W | Captured read data |
| bus_addr | output | ADDR_W | Bus address lines |
| bus_as | output | 1 | Address strobe |
| bus_rnw | output | 1 | 1 = read, 0 = write |
| bus_wait | input | 1 | Slave stretch request |
| bus_dout | output | DATA_W | Value to drive onto the data lines |
| bus_doe | output | 1 | Data line output enable |
| bus_din | input | DATA_W | Value seen on the data lines |

## Verification
The bench slave changes the read data so that `bus_din` holds the correct word only at the single edge where WAIT drops. A design that captures one edge early or late therefore returns the complement of the word. Wait counts of zero, one and three, and a WAIT held past the limit, show whether the design adds one Tw per high sample, or instead skips the wait check or miscounts the timeout by one. WAIT pulses placed in T1 and T3 catch a design that samples WAIT in the wrong phase. The per-cycle comparison of output enable, strobe and address catches an enable that starts in T1, drives on reads, or leaves a cycle with no strobe between transfers.

// File: rtl/sbus_pkg.sv
package sbus_pkg;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_T1    = 3'd1,
        PH_T2    = 3'd2,
        PH_TW    = 3'd3,
        PH_T3    = 3'd4,
        PH_ABORT = 3'd5
    } phase_e;

    // Phases in which the address strobe is asserted.
    function automatic logic strobe_phase(phase_e p);
        return (p == PH_T1) || (p == PH_T2) || (p == PH_TW) || (p == PH_T3);
    endfunction

    // Phases in which write data may be driven.
    function automatic logic data_phase(phase_e p);
        return (p == PH_T2) || (p == PH_TW) || (p == PH_T3);
    endfunction

    // Phases that end with a WAIT sample.
    function automatic logic wait_sample_phase(phase_e p);
        return (p == PH_T2) || (p == PH_TW);
    endfunction

endpackage

// File: rtl/sbus_phase_fsm.sv
module sbus_phase_fsm
    import sbus_pkg::*;
#(
    parameter int WAIT_LIMIT = 16
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    input  logic   bus_wait,
    output phase_e phase,
    output logic   capture
);
    localparam int CNT_W = $clog2(WAIT_LIMIT + 1);
    localparam logic [CNT_W-1:0] LAST_TW = CNT_W'(WAIT_LIMIT - 1);

    phase_e           phase_q, phase_d;
    logic [CNT_W-1:0] tw_cnt_q;

    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            PH_IDLE:  if (start) phase_d = PH_T1;
            PH_T1:    phase_d = PH_T2;
            PH_T2:    phase_d = bus_wait ? PH_TW : PH_T3;
            PH_TW: begin
                if (!bus_wait)               phase_d = PH_T3;
                else if (tw_cnt_q == LAST_TW) phase_d = PH_ABORT;
                else                          phase_d = PH_TW;
            end
            PH_T3:    phase_d = PH_IDLE;
            PH_ABORT: phase_d = PH_IDLE;
            default:  phase_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q  <= PH_IDLE;
            tw_cnt_q <= '0;
        end else begin
            phase_q <= phase_d;
            if (phase_q == PH_T2)
                tw_cnt_q <= '0;
            else if (phase_q == PH_TW && bus_wait)
                tw_cnt_q <= tw_cnt_q + 1'b1;
        end
    end

    assign phase   = phase_q;
    assign capture = wait_sample_phase(phase_q) && !bus_wait;

endmodule

// File: rtl/sbus_xfer_regs.sv
module sbus_xfer_regs #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              capture,
    input  logic [DATA_W-1:0] bus_din,
    output logic [ADDR_W-1:0] addr_q,
    output logic              write_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic [DATA_W-1:0] rdata_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            write_q <= 1'b0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else if (load) begin
            addr_q  <= req_addr;
            write_q <= req_write;
            wdata_q <= req_wdata;
            rdata_q <= '0;
        end else if (capture && !write_q) begin
            rdata_q <= bus_din;
        end
    end

endmodule

// File: rtl/sbus_master.sv
module sbus_master
    import sbus_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int WAIT_LIMIT = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_as,
    output logic              bus_rnw,
    input  logic              bus_wait,
    output logic [DATA_W-1:0] bus_dout,
    output logic              bus_doe,
    input  logic [DATA_W-1:0] bus_din
);
    phase_e            phase;
    logic              capture;
    logic              accept;
    logic              write_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;

    assign req_ready = (phase == PH_IDLE);
    assign accept    = req_valid && req_ready;

    sbus_phase_fsm #(
        .WAIT_LIMIT(WAIT_LIMIT)
    ) i_fsm (
        .clk     (clk),
        .rst     (rst),
        .start   (accept),
        .bus_wait(bus_wait),
        .phase   (phase),
        .capture (capture)
    );

    sbus_xfer_regs #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) i_regs (
        .clk      (clk),
        .rst      (rst),
        .load     (accept),
        .req_write(req_write),
        .req_addr (req_addr),
        .req_wdata(req_wdata),
        .capture  (capture),
        .bus_din  (bus_din),
        .addr_q   (addr_q),
        .write_q  (write_q),
        .wdata_q  (wdata_q),
        .rdata_q  (rdata_q)
    );

    assign bus_addr  = addr_q;
    assign bus_rnw   = !write_q;
    assign bus_as    = strobe_phase(phase);
    assign bus_doe   = write_q && data_phase(phase);
    assign bus_dout  = wdata_q;
    assign rsp_valid = (phase == PH_T3) || (phase == PH_ABORT);
    assign rsp_err   = (phase == PH_ABORT);
    assign rsp_rdata = rdata_q;

endmodule

// File: rtl/sbus_master_chk.sv
module sbus_master_chk #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              rsp_err,
    input logic [DATA_W-1:0] rsp_rdata,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_as,
    input logic              bus_rnw,
    input logic              bus_doe
);
    assert_strobe_not_ready_R1: assert property (@(posedge clk) disable iff (rst)
        bus_as |-> !req_ready);

    assert_t2_follows_t1_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_as) |=> bus_as);

    assert_done_inside_strobe_R2: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_err) |-> bus_as);

    assert_addr_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_as && $past(bus_as)) |-> ($stable(bus_addr) && $stable(bus_rnw)));

    assert_gap_after_t3_R4: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_err) |=> !bus_as);

    assert_doe_write_only_R5: assert property (@(posedge clk) disable iff (rst)
        bus_doe |-> (!bus_rnw && bus_as));

    assert_doe_not_in_t1_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_as) |-> !bus_doe);

    assert_abort_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        rsp_err |-> (rsp_valid && !bus_as && !bus_doe && rsp_rdata == '0));

    assert_single_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

endmodule

bind sbus_master sbus_master_chk #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
) i_chk (
    .clk      (clk),
    .rst      (rst),
    .req_ready(req_ready),
    .rsp_valid(rsp_valid),
    .rsp_err  (rsp_err),
    .rsp_rdata(rsp_rdata),
    .bus_addr (bus_addr),
    .bus_as   (bus_as),
    .bus_rnw  (bus_rnw),
    .bus_doe  (bus_doe)
);

// File: tb/test_sbus_master.sv
module test_sbus_master;
    localparam int AW    = 32;
    localparam int DW    = 32;
    localparam int LIMIT = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          rsp_valid;
    logic          rsp_err;
    logic [DW-1:0] rsp_rdata;
    logic [AW-1:0] bus_addr;
    logic          bus_as;
    logic          bus_rnw;
    logic          bus_wait = 1'b0;
    logic [DW-1:0] bus_dout;
    logic          bus_doe;
    logic [DW-1:0] bus_din = '0;

    always #5 clk = ~clk;

    sbus_master #(
        .ADDR_W(AW), .DATA_W(DW), .WAIT_LIMIT(LIMIT)
    ) i_sbus_master (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .bus_addr(bus_addr), .bus_as(bus_as), .bus_rnw(bus_rnw),
        .bus_wait(bus_wait), .bus_dout(bus_dout), .bus_doe(bus_doe),
        .bus_din(bus_din)
    );

    typedef struct {
        logic [DW-1:0] rdata;
        logic          err;
        int            lat;
    } exp_t;

    exp_t          sb_q[$];
    int            checks = 0;
    int            errors = 0;

    // Slave configuration for the transfer in flight.
    int            sl_n    = 0;
    logic          sl_spur = 1'b0;
    logic [DW-1:0] sl_rd   = '0;
    logic [AW-1:0] ex_addr = '0;
    logic          ex_wr   = 1'b0;
    logic [DW-1:0] ex_wd   = '0;
    int            since   = 0;
    int            k       = 0;
    logic          prev_rsp = 1'b0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic xfer(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                        input logic [DW-1:0] rd, input int nwait, input logic spur);
        exp_t e;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        sl_n = nwait; sl_spur = spur; sl_rd = rd;
        ex_addr = a; ex_wr = wr; ex_wd = wd;
        e.err   = (nwait > LIMIT);
        e.rdata = (wr || e.err) ? '0 : rd;
        e.lat   = e.err ? LIMIT + 3 : nwait + 3;
        sb_q.push_back(e);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
        @(posedge clk);
        #1;
        since = 0;
        req_valid = 1'b0;
    endtask

    // Slave model and response monitor.
    always @(negedge clk) begin
        if (!rst) begin
            since++;
            if (bus_as) begin
                k++;
                chk(req_ready == 1'b0, "R1 ready during transfer", req_ready, 0);
                chk(bus_addr == ex_addr, "R3 address", bus_addr, ex_addr);
                chk(bus_rnw == !ex_wr, "R3 direction", bus_rnw, !ex_wr);
                chk(bus_doe == (ex_wr && k >= 2), "R5 output enable", bus_doe, ex_wr && k >= 2);
                if (bus_doe) chk(bus_dout == ex_wd, "R5 write data", bus_dout, ex_wd);
            end else begin
                k = 0;
                chk(bus_doe == 1'b0, "R5 enable while idle", bus_doe, 0);
            end
            bus_wait = bus_as && (((k >= 2) && (k <= sl_n + 1)) ||
                                  (sl_spur && (k == 1 || k == sl_n + 3)));
            bus_din  = (bus_as && k == sl_n + 2) ? sl_rd : ~sl_rd;

            chk(!(rsp_valid && prev_rsp), "R10 pulse width", 1, 0);
            if (rsp_valid) begin
                if (sb_q.size() == 0) begin
                    chk(1'b0, "R10 unexpected response", 1, 0);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    chk(rsp_rdata == e.rdata, "R7 read data", rsp_rdata, e.rdata);
                    chk(rsp_err == e.err, "R9 error flag", rsp_err, e.err);
                    chk(since == e.lat, "R6 response latency", since, e.lat);
                    chk(bus_as == !e.err, "R4 strobe at completion", bus_as, !e.err);
                end
            end
            prev_rsp = rsp_valid;
        end
    end

    initial begin
        repeat (5) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1 reset ready", req_ready, 1);
        chk(bus_as == 1'b0, "R1 reset strobe", bus_as, 0);
        chk(bus_doe == 1'b0, "R1 reset enable", bus_doe, 0);
        chk(rsp_valid == 1'b0, "R1 reset response", rsp_valid, 0);

        fork
            begin
                xfer(1'b0, 32'h0000_1000, 32'h0, 32'hA5A5_0001, 0, 1'b0); // R2 read
                xfer(1'b1, 32'h0000_1004, 32'h1234_5678, 32'h0, 0, 1'b0); // R2 R5 write
                xfer(1'b0, 32'h0000_2000, 32'h0, 32'hC0DE_0002, 1, 1'b0); // R6 R7
                xfer(1'b1, 32'h0000_2004, 32'hBEEF_0003, 32'h0, 3, 1'b0); // R6 R5
                xfer(1'b0, 32'h0000_3000, 32'h0, 32'h0F0F_0004, 0, 1'b1); // R8
                xfer(1'b1, 32'h0000_3004, 32'h7777_0005, 32'h0, 2, 1'b1); // R8
                xfer(1'b0, 32'h0000_4000, 32'h0, 32'h5555_0006, LIMIT, 1'b0); // R9 edge: no abort
                xfer(1'b0, 32'h0000_4004, 32'h0, 32'h6666_0007, 50, 1'b0); // R9 abort read
                xfer(1'b1, 32'h0000_4008, 32'h8888_0008, 32'h0, 50, 1'b0); // R9 abort write
                for (int i = 0; i < 4; i++)                                // R4 back to back
                    xfer(i[0], 32'h5000 + 32'(i * 4), 32'h9000 + 32'(i), 32'hD000 + 32'(i), i, 1'b0);
                @(negedge clk);
                while (!req_ready) @(negedge clk);
                repeat (3) @(negedge clk);
                chk(sb_q.size() == 0, "R10 responses outstanding", sb_q.size(), 0);
            end
            begin
                repeat (20000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: run did not complete");
            end
        join_any
        disable fork;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule